// File: doc/BRIEF.md
# Synchronized-Update PWM Generator

This block produces one pulse-width-modulated output from a single counter. The counter either counts down from a period value to zero and reloads, or counts up to the period value and back down to zero. Each cycle the count is checked against zero, the period value and two compare values. An action word picks what each of these events does to the output: nothing, toggle, force low or force high.

Software writes the period, the two compare values and the action word through a plain write port. Each write goes into a shadow copy first. A control word sets, for each register, when the shadow reaches the active logic. The options are at once, at the next counter zero, or at the first counter zero after a global sync pulse. Several registers can therefore be changed together without the output ever seeing a mix of old and new values. A debug input can park the counter at zero. A control bit lets the counter ignore that input.

Top module: `pwm_sync_gen`

## Requirements
- R1: After reset the control word is all zeros, every active register is 0, `cnt_o` is 0 and `pwm_o` is 0.
- R2: While control bit 0 (enable) is 0, `cnt_o` is 0 and `pwm_o` is 0 from the next cycle on, and no deferred register transfer takes place.
- R3: With control bit 1 = 0, the counter steps down by one each cycle. In a cycle where it is 0 it loads the period value in force, so one period is period+1 cycles.
- R4: With control bit 1 = 1, the counter rises from 0 to the period value and falls back to 0, so one period is 2×period cycles. While enabled, `cnt_o` never exceeds the period value in force.
- R5: `reg_sel_i` picks 0 = period, 1 = compare A, 2 = compare B, 3 = action word (data bits 11:0). Each of the first three has its own update bit: control bit 3, 4 and 5 in that order. When that bit is 0, a written value comes into force in the next enabled cycle where the count is 0, and a period written this way is the one reloaded there.
- R6: When that update bit is 1, a written value comes into force only at the first enabled zero that follows a cycle with `sync_req_i` = 1 while the write was waiting.
- R7: Control bits 7:6 set the action-word timing. Codes 0 and 1 put a write in force in the write cycle itself. Code 2 behaves like R5 and code 3 behaves like R6.
- R8: With control bit 2 = 0 and `dbg_halt_i` = 1, the counter stops once it reaches 0 and stays there. The output does not change while it is held. Counting resumes after `dbg_halt_i` falls.
- R9: With control bit 2 = 1, `dbg_halt_i` has no effect on counting.
- R10: The action word holds one 2-bit code (0 none, 1 toggle, 2 low, 3 high) per event. The events are, from bits 1:0 upward: count = 0, count = period, A match rising, A match falling, B match rising, B match falling. A cycle counts as rising only in up/down mode, when it was reached by an increment or is the first count after the counter left its idle state. Events of the current cycle are applied in the order zero, period, A, B, so B wins a tie. The result appears on `pwm_o` one cycle later.
- R11: A sync pulse only arms registers whose write is already waiting. A write made after the pulse needs another pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Write strobe for the control word |
| ctrl_i | input | 8 | Control word value |
| reg_wr_i | input | 1 | Write strobe for a shadow register |
| reg_sel_i | input | 2 | Shadow register select |
| reg_data_i | input | CNT_W | Shadow register write data |
| sync_req_i | input | 1 | Global sync request, one-cycle pulse |
| dbg_halt_i | input | 1 | Debug halt request |
| cnt_o | output | CNT_W | Current counter value |
| pwm_o | output | 1 | PWM output |

## Verification
Several properties are checked in every cycle. A deferred register only changes at an enabled zero or on an immediate write, and a globally timed one only after it was armed. The down-count step, the bound on the count, the park at zero under debug, the disabled state and the B-over-A priority are also checked each cycle. Other behaviours need a chosen history and are left to the bench scenarios, which compare each cycle against a behavioural model. These are the full waveform shapes, the exact zero at which grouped writes land, a sync pulse that arrives before its write, and the reserved action-timing code.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned ACT_W     = 12;
  localparam int unsigned N_EVT     = 6;
  localparam int unsigned N_NUM     = 3;
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_MODE   = 1;
  localparam int unsigned CB_DBG    = 2;
  localparam int unsigned CB_UPD0   = 3;
  localparam int unsigned CB_ACTUPD = 6;
  localparam logic [1:0]  SEL_ACT   = 2'd3;

  typedef enum logic [1:0] {UPD_IMM, UPD_LOCAL, UPD_GLOBAL} upd_pol_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_INV, ACT_LOW, ACT_HIGH} act_e;

  function automatic upd_pol_e num_pol(logic b);
    return b ? UPD_GLOBAL : UPD_LOCAL;
  endfunction

  function automatic upd_pol_e act_pol(logic [1:0] code);
    case (code)
      2'd2:    return UPD_LOCAL;
      2'd3:    return UPD_GLOBAL;
      default: return UPD_IMM;  // code 1 reserved, treated as 0
    endcase
  endfunction

  function automatic logic apply_act(logic cur, logic [1:0] code);
    case (act_e'(code))
      ACT_INV:  return ~cur;
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg
  import pwm_sync_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  upd_pol_e     pol_i,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         zero_i,
  input  logic         sync_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] shad_q, act_q, act_d;
  logic         dirty_q, armed_q, xfer, imm_wr;

  assign xfer   = zero_i && ((pol_i == UPD_LOCAL  && dirty_q) ||
                             (pol_i == UPD_GLOBAL && armed_q));
  assign imm_wr = wr_i && (pol_i == UPD_IMM);
  assign act_d  = imm_wr ? data_i : (xfer ? shad_q : act_q);
  assign val_o  = act_d;  // value in force this cycle

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shad_q  <= '0;
      act_q   <= '0;
      dirty_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      act_q <= act_d;
      if (wr_i) shad_q <= data_i;
      if (wr_i)      dirty_q <= !imm_wr;
      else if (xfer) dirty_q <= 1'b0;
      armed_q <= xfer ? 1'b0 : (armed_q | (sync_i & dirty_q));
    end
  end

  p_defer_only_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(zero_i || (wr_i && pol_i == UPD_IMM)));

  p_global_needs_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_q) && $past(pol_i == UPD_GLOBAL)) |-> $past(armed_q));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             updown_i,
  input  logic             dbg_run_i,
  input  logic             dbg_halt_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             zero_o,
  output logic             fresh_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d, held_q, halt;

  assign halt = en_i && !dbg_run_i && dbg_halt_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!en_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (halt) begin
      cnt_d = cnt_q;
    end else if (!updown_i) begin
      up_d  = 1'b1;
      cnt_d = (cnt_q == '0) ? load_i : cnt_q - ONE;
    end else if (up_q) begin
      if (cnt_q >= load_i) begin
        up_d  = 1'b0;
        cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (cnt_q == '0) begin
      up_d  = 1'b1;
      cnt_d = (load_i == '0) ? '0 : ONE;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      held_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      held_q <= halt;
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_up_o = updown_i && up_q;
  assign zero_o   = en_i && (cnt_q == '0);
  assign fresh_o  = !held_q;

  p_down_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !updown_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  p_park_at_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dbg_run_i && dbg_halt_i && cnt_q == '0) |=> (cnt_q == '0));

  p_debug_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dbg_run_i && dbg_halt_i && !updown_i && cnt_q == '0 && load_i != '0)
      |=> (cnt_q == $past(load_i)));
endmodule

// File: rtl/pwm_out_logic.sv
module pwm_out_logic
  import pwm_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fresh_i,
  input  logic             dir_up_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cmpb_i,
  input  logic [ACT_W-1:0] act_i,
  output logic             pwm_o
);
  logic [N_EVT-1:0] evt;
  logic             pwm_q, pwm_d, walk;

  assign evt[0] = (cnt_i == '0);
  assign evt[1] = (cnt_i == load_i);
  assign evt[2] = (cnt_i == cmpa_i) &&  dir_up_i;
  assign evt[3] = (cnt_i == cmpa_i) && !dir_up_i;
  assign evt[4] = (cnt_i == cmpb_i) &&  dir_up_i;
  assign evt[5] = (cnt_i == cmpb_i) && !dir_up_i;

  // ascending index = ascending priority
  always_comb begin
    walk = pwm_q;
    for (int i = 0; i < N_EVT; i++) begin
      if (evt[i]) walk = apply_act(walk, act_i[2*i +: 2]);
    end
    if (!en_i)         pwm_d = 1'b0;
    else if (fresh_i)  pwm_d = walk;
    else               pwm_d = pwm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  p_b_beats_a_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fresh_i && !dir_up_i && cnt_i == cmpb_i && act_i[11:10] == 2'd3) |=> pwm_o);

  p_held_output_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fresh_i) |=> $stable(pwm_o));
endmodule

// File: rtl/pwm_sync_gen.sv
module pwm_sync_gen
  import pwm_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [CNT_W-1:0]  reg_data_i,
  input  logic              sync_req_i,
  input  logic              dbg_halt_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pwm_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  num_val [N_NUM];
  logic [ACT_W-1:0]  act_val;
  logic              zero, dir_up, fresh, en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_i;
  end

  assign en = ctrl_q[CB_EN];

  // 0: period, 1: compare A, 2: compare B
  for (genvar g = 0; g < N_NUM; g++) begin : g_num
    pwm_shadow_reg #(.W(CNT_W)) u_shadow (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pol_i  (num_pol(ctrl_q[CB_UPD0+g])),
      .wr_i   (reg_wr_i && reg_sel_i == 2'(g)),
      .data_i (reg_data_i),
      .zero_i (zero),
      .sync_i (sync_req_i),
      .val_o  (num_val[g])
    );
  end

  pwm_shadow_reg #(.W(ACT_W)) u_act_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pol_i  (act_pol(ctrl_q[CB_ACTUPD +: 2])),
    .wr_i   (reg_wr_i && reg_sel_i == SEL_ACT),
    .data_i (reg_data_i[ACT_W-1:0]),
    .zero_i (zero),
    .sync_i (sync_req_i),
    .val_o  (act_val)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .updown_i   (ctrl_q[CB_MODE]),
    .dbg_run_i  (ctrl_q[CB_DBG]),
    .dbg_halt_i (dbg_halt_i),
    .load_i     (num_val[0]),
    .cnt_o      (cnt_o),
    .dir_up_o   (dir_up),
    .zero_o     (zero),
    .fresh_o    (fresh)
  );

  pwm_out_logic #(.CNT_W(CNT_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .fresh_i  (fresh),
    .dir_up_i (dir_up),
    .cnt_i    (cnt_o),
    .load_i   (num_val[0]),
    .cmpa_i   (num_val[1]),
    .cmpb_i   (num_val[2]),
    .act_i    (act_val),
    .pwm_o    (pwm_o)
  );

  p_idle_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (cnt_o == '0 && !pwm_o));

  p_cnt_bounded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |-> (cnt_o <= num_val[0]));

  p_act_immediate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i == SEL_ACT && !ctrl_q[CB_ACTUPD+1])
      |-> (act_val == reg_data_i[ACT_W-1:0]));
endmodule

// File: tb/pwm_sync_gen_bench.sv
module pwm_sync_gen_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctrl_wr = 1'b0;
  logic [7:0]   ctrl_d = '0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_sel = '0;
  logic [W-1:0] reg_d = '0;
  logic         sync = 1'b0;
  logic         dbg = 1'b0;
  logic [W-1:0] cnt;
  logic         pwm;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  pwm_sync_gen #(.CNT_W(W)) u_pwm_sync_gen (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_i(ctrl_d),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_data_i(reg_d),
    .sync_req_i(sync), .dbg_halt_i(dbg), .cnt_o(cnt), .pwm_o(pwm)
  );

  // ---------------- behavioural model ----------------
  logic [7:0] m_ctrl;
  int  m_cnt, m_up, m_held, m_pwm;
  int  m_act[4], m_sh[4], m_dirty[4], m_armed[4];

  function automatic int timing(int idx, logic [7:0] c);  // 0 imm, 1 next zero, 2 after sync
    if (idx < 3) return c[3+idx] ? 2 : 1;
    if (c[7:6] == 2'd3) return 2;
    if (c[7:6] == 2'd2) return 1;
    return 0;
  endfunction

  function automatic int do_act(int cur, int code);
    if (code == 1) return 1 - cur;
    if (code == 2) return 0;
    if (code == 3) return 1;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_cnt = 0; m_up = 1; m_held = 0; m_pwm = 0;
      for (int i = 0; i < 4; i++) begin
        m_act[i] = 0; m_sh[i] = 0; m_dirty[i] = 0; m_armed[i] = 0;
      end
    end else begin
      int nv[4];
      int en, md, run, atz, rising, p, halt, go;
      en  = m_ctrl[0]; md = m_ctrl[1]; run = m_ctrl[2];
      atz = en && (m_cnt == 0);
      for (int i = 0; i < 4; i++) begin
        int t, hit;
        t = timing(i, m_ctrl);
        go = atz && ((t == 1 && m_dirty[i] != 0) || (t == 2 && m_armed[i] != 0));
        nv[i] = go ? m_sh[i] : m_act[i];
        hit = reg_wr && (int'(reg_sel) == i);
        if (hit && t == 0) nv[i] = int'(reg_d[11:0]);
        m_armed[i] = go ? 0 : ((m_armed[i] != 0 || (sync && m_dirty[i] != 0)) ? 1 : 0);
        if (hit) begin
          m_sh[i] = (i == 3) ? int'(reg_d[11:0]) : int'(reg_d);
          m_dirty[i] = (t != 0);
        end else if (go) m_dirty[i] = 0;
        m_act[i] = nv[i];
      end
      // output events
      rising = md && m_up;
      p = m_pwm;
      if (m_cnt == 0)     p = do_act(p, nv[3] & 3);
      if (m_cnt == nv[0]) p = do_act(p, (nv[3] >> 2) & 3);
      if (m_cnt == nv[1]) p = do_act(p, (nv[3] >> (rising ? 4 : 6)) & 3);
      if (m_cnt == nv[2]) p = do_act(p, (nv[3] >> (rising ? 8 : 10)) & 3);
      if (!en) m_pwm = 0;
      else if (m_held == 0) m_pwm = p;
      // counter
      halt = en && !run && dbg && m_cnt == 0;
      if (!en) begin m_cnt = 0; m_up = 1; end
      else if (halt) begin end
      else if (!md) begin m_up = 1; m_cnt = (m_cnt == 0) ? nv[0] : m_cnt - 1; end
      else if (m_up != 0) begin
        if (m_cnt >= nv[0]) begin m_up = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin m_up = 1; m_cnt = (nv[0] == 0) ? 0 : 1; end
        else m_cnt = m_cnt - 1;
      end
      m_held = halt;
      if (ctrl_wr) m_ctrl = ctrl_d;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " cnt_o vs model"}, int'(cnt), m_cnt);
      chk({phase, " pwm_o vs model"}, int'(pwm), m_pwm);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr_ctrl(logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_d = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] s, logic [W-1:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_d = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peak(int n, output int mx);
    mx = 0;
    repeat (n) begin
      @(negedge clk);
      if (int'(cnt) > mx) mx = int'(cnt);
    end
  endtask

  initial begin
    int mx, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cnt_o", int'(cnt), 0);
    chk("R1 reset pwm_o", int'(pwm), 0);

    phase = "R2";
    wr_reg(2'd0, 16'd5);
    wr_reg(2'd1, 16'd2);
    wr_reg(2'd3, 16'h0083);      // zero->high, A falling->low
    idle(10);
    chk("R2 disabled cnt_o", int'(cnt), 0);
    chk("R2 disabled pwm_o", int'(pwm), 0);

    phase = "R3";
    wr_ctrl(8'h01);
    idle(30);

    phase = "R5";
    wr_reg(2'd0, 16'd3);
    seen = 0;
    for (int i = 0; i < 20 && seen == 0; i++) begin
      @(negedge clk);
      if (cnt == '0) seen = 1;
    end
    @(negedge clk);
    chk("R5 new period reloaded at zero", int'(cnt), 3);
    idle(15);

    phase = "R4";
    wr_ctrl(8'h03);
    wr_reg(2'd3, 16'h00B0);      // A rising->high, A falling->low
    idle(10);
    peak(20, mx);
    chk("R4 peak equals period", mx, 3);

    phase = "R6";
    wr_ctrl(8'h3B);
    wr_reg(2'd0, 16'd6);
    peak(30, mx);
    chk("R6 no transfer before sync", mx, 3);
    pulse_sync();
    idle(10);
    peak(30, mx);
    chk("R6 transfer after sync", mx, 6);

    phase = "R11";
    pulse_sync();
    wr_reg(2'd0, 16'd2);
    peak(30, mx);
    chk("R11 early pulse does not arm", mx, 6);
    pulse_sync();
    idle(15);
    peak(20, mx);
    chk("R11 second pulse arms", mx, 2);

    phase = "R7";
    wr_ctrl(8'h41);              // reserved code -> immediate
    wr_reg(2'd3, 16'h0003);
    idle(12);
    wr_ctrl(8'h81);
    wr_reg(2'd3, 16'h0002);
    idle(12);
    wr_ctrl(8'hC1);
    wr_reg(2'd3, 16'h0001);
    idle(15);
    pulse_sync();
    idle(15);
    wr_ctrl(8'h01);

    phase = "R10";
    wr_reg(2'd0, 16'd4);
    wr_reg(2'd1, 16'd1);
    wr_reg(2'd2, 16'd1);
    wr_reg(2'd3, 16'h08C0);      // A falling->high, B falling->low
    idle(25);
    wr_reg(2'd3, 16'h0004);      // toggle at period
    idle(25);
    wr_ctrl(8'h03);
    wr_reg(2'd3, 16'h0730);      // up/down mix of A and B codes
    idle(30);

    phase = "R8";
    wr_ctrl(8'h01);
    wr_reg(2'd3, 16'h0004);
    dbg = 1'b1;
    idle(10);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 parked at zero", int'(cnt), 0);
    end
    dbg = 1'b0;
    idle(12);

    phase = "R9";
    wr_ctrl(8'h05);
    dbg = 1'b1;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cnt != '0) seen = 1;
    end
    chk("R9 counting despite halt request", seen, 1);
    dbg = 1'b0;
    idle(8);

    phase = "R2";
    wr_ctrl(8'h00);
    idle(2);
    chk("R2 disable clears cnt_o", int'(cnt), 0);
    chk("R2 disable clears pwm_o", int'(pwm), 0);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule